// File: doc/BRIEF.md
# Grouped Edge-Event Interrupt Collector

This block watches thirty-two digital input lines. Twenty-four of them are isolated inputs and eight are TTL/CMOS lines, and they are arranged as four groups of eight. Each line passes through a two-flop synchronizer. The block then compares the settled sample with the sample taken one clock earlier. A line that moved in a direction its group has enabled sets a sticky status bit. A single level interrupt stays high while any status bit is set and the global interrupt-enable input is high.

Software reaches the block through a byte-wide register port with a 4-bit address. A read returns the four status bytes or the edge-enable byte. A write to a status byte does not store data: it clears only the bits written as 1. Software can therefore hand back exactly the value it just read and acknowledge exactly those events. A write to the enable byte sets the rising and falling detection for each group.

Top module: `edge_irq_top`

## Requirements
- R1: After a synchronous reset, every one of the 16 register addresses reads 0x00 and `irqOut` is low. Reset clears the status bits, the enable byte and the synchronizer and edge history.
- R2: The enable byte at address 0xE is readable and writable. Bit g (g=0..3) enables rising-edge detection for group g, and bit 4+g enables falling-edge detection for group g.
- R3: Line n belongs to group n/8 and reports at bit n%8 of the status byte at address 0x8+n/8. Lines 0..23 are the isolated inputs, and lines 24..31 are the TTL group at 0xB. A 0-to-1 change on a line whose group has its rising bit set sets that status bit.
- R4: A 1-to-0 change on a line whose group has its falling bit set sets that line's status bit.
- R5: A group with both enable bits set records either direction. A group with neither bit set records nothing.
- R6: A write to addresses 0x8..0xB clears exactly the status bits written as 1. Bits written as 0 keep their value.
- R7: If an enabled edge on a bit is recorded in the same cycle that a clear for that bit is written, the bit stays set.
- R8: `irqOut` is high exactly when at least one status bit is set and `globalIrqEn` is high. Status bits remain set, whatever `globalIrqEn` does, until they are cleared.
- R9: Reads from addresses 0x0..0x7, 0xC, 0xD and 0xF return 0x00. Writes to those addresses change neither the status bits nor the enable byte.
- R10: A level held on `lineIn` from just after rising edge k appears in status after rising edge k+3. The enable byte in force during the cycle before that edge decides whether it is recorded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| lineIn | input | 32 | Watched lines; bits 24..31 are the TTL group |
| busAddr | input | 4 | Register address |
| busWrEn | input | 1 | Write strobe for the current address |
| busWrData | input | 8 | Write data |
| busRdData | output | 8 | Read data for `busAddr`, combinational |
| globalIrqEn | input | 1 | Global gate for the interrupt output |
| irqOut | output | 1 | Level interrupt |

## Verification
Two functions can fall in the same clock: a software clear of a status byte, and a newly settled edge on one of that byte's lines. The bench provokes this on purpose. It changes a line exactly three edges before a clear that names the same bit, and it also lets random writes land on status addresses while random lines toggle. Each outcome is judged against a cycle-stepped bench model in which the new event takes precedence over the clear, so a dropped event or a surviving stale bit shows up as a miscompare on the status read.

// File: rtl/edge_irq_pkg.sv
package edge_irq_pkg;
  localparam int GROUPS  = 4;
  localparam int GROUP_W = 8;
  localparam int NLINES  = GROUPS * GROUP_W;

  // strobes and settings handed from control to datapath
  typedef struct packed {
    logic [NLINES-1:0] clrMask;
    logic [GROUPS-1:0] riseEn;
    logic [GROUPS-1:0] fallEn;
  } ctrl_strobe_t;
endpackage

// File: rtl/edge_irq_path.sv
module edge_irq_path
  import edge_irq_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NLINES-1:0] lineIn,
  input  ctrl_strobe_t      strobe,
  output logic [NLINES-1:0] statusQ
);
  localparam int LAST = SYNC_STAGES - 1;

  logic [SYNC_STAGES-1:0][NLINES-1:0] syncQ;
  logic [NLINES-1:0] histQ;
  logic [NLINES-1:0] riseSeen, fallSeen;
  logic [NLINES-1:0] riseMask, fallMask;
  logic [NLINES-1:0] hitVec;

  // synchronizer chain and one-sample edge history
  always_ff @(posedge clk) begin
    if (rst) begin
      syncQ <= '0;
      histQ <= '0;
    end else begin
      syncQ[0] <= lineIn;
      for (int s = 1; s < SYNC_STAGES; s++) syncQ[s] <= syncQ[s-1];
      histQ <= syncQ[LAST];
    end
  end

  assign riseSeen = syncQ[LAST] & ~histQ;
  assign fallSeen = ~syncQ[LAST] & histQ;

  // widen the per-group enables to per-line masks
  for (genvar g = 0; g < GROUPS; g++) begin : g_grp
    assign riseMask[g*GROUP_W +: GROUP_W] = {GROUP_W{strobe.riseEn[g]}};
    assign fallMask[g*GROUP_W +: GROUP_W] = {GROUP_W{strobe.fallEn[g]}};
  end

  assign hitVec = (riseSeen & riseMask) | (fallSeen & fallMask);

  // new events win over a clear in the same cycle
  always_ff @(posedge clk) begin
    if (rst) statusQ <= '0;
    else     statusQ <= (statusQ & ~strobe.clrMask) | hitVec;
  end

  // a bit can only become set by an enabled edge
  p_set_needs_edge_r5: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((statusQ & ~$past(statusQ) & ~$past(hitVec)) == '0));

  // bits not named by a clear keep their value
  p_sticky_r6: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((statusQ & $past(statusQ & ~strobe.clrMask)) == $past(statusQ & ~strobe.clrMask)));

  // a clear with no concurrent event empties the bit; with one, the bit holds
  p_clear_r7: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((statusQ & $past(strobe.clrMask & ~hitVec)) == '0));
  p_event_wins_r7: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((statusQ & $past(hitVec)) == $past(hitVec)));
endmodule

// File: rtl/edge_irq_ctrl.sv
module edge_irq_ctrl
  import edge_irq_pkg::*;
#(
  parameter int          ADDR_W      = 4,
  parameter int          DATA_W      = 8,
  parameter logic [3:0]  STATUS_BASE = 4'h8,
  parameter logic [3:0]  ENABLE_ADDR = 4'hE
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  input  logic [DATA_W-1:0] busWrData,
  input  logic [NLINES-1:0] statusQ,
  output logic [DATA_W-1:0] busRdData,
  output ctrl_strobe_t      strobe
);
  localparam int EN_W = 2 * GROUPS;

  logic [EN_W-1:0] enableQ;
  logic            enWrite;
  logic            mapped;

  assign enWrite = busWrEn && (busAddr == ADDR_W'(ENABLE_ADDR));

  always_ff @(posedge clk) begin
    if (rst)          enableQ <= '0;
    else if (enWrite) enableQ <= busWrData[EN_W-1:0];
  end

  assign strobe.riseEn = enableQ[GROUPS-1:0];
  assign strobe.fallEn = enableQ[EN_W-1:GROUPS];

  // write-one-to-clear decode per status byte
  for (genvar g = 0; g < GROUPS; g++) begin : g_clr
    assign strobe.clrMask[g*GROUP_W +: GROUP_W] =
      (busWrEn && busAddr == ADDR_W'(STATUS_BASE + g)) ? busWrData[GROUP_W-1:0] : '0;
  end

  always_comb begin
    busRdData = '0;
    mapped    = 1'b0;
    if (busAddr == ADDR_W'(ENABLE_ADDR)) begin
      busRdData = DATA_W'(enableQ);
      mapped    = 1'b1;
    end
    for (int g = 0; g < GROUPS; g++) begin
      if (busAddr == ADDR_W'(STATUS_BASE + g)) begin
        busRdData = DATA_W'(statusQ[g*GROUP_W +: GROUP_W]);
        mapped    = 1'b1;
      end
    end
  end

  p_enable_write_r2: assert property (@(posedge clk) disable iff (rst)
    enWrite |=> (enableQ == $past(busWrData[EN_W-1:0])));
  p_enable_hold_r9: assert property (@(posedge clk) disable iff (rst)
    !enWrite |=> $stable(enableQ));
  p_unmapped_zero_r9: assert property (@(posedge clk) disable iff (rst)
    !mapped |-> (busRdData == '0));
endmodule

// File: rtl/edge_irq_top.sv
module edge_irq_top
  import edge_irq_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic [31:0] lineIn,
  input  logic [3:0]  busAddr,
  input  logic        busWrEn,
  input  logic [7:0]  busWrData,
  output logic [7:0]  busRdData,
  input  logic        globalIrqEn,
  output logic        irqOut
);
  ctrl_strobe_t      strobe;
  logic [NLINES-1:0] statusQ;

  edge_irq_ctrl #(.ADDR_W(4), .DATA_W(8)) u_ctrl (
    .clk(clk), .rst(rst), .busAddr(busAddr), .busWrEn(busWrEn),
    .busWrData(busWrData), .statusQ(statusQ), .busRdData(busRdData),
    .strobe(strobe)
  );

  edge_irq_path #(.SYNC_STAGES(2)) u_path (
    .clk(clk), .rst(rst), .lineIn(lineIn), .strobe(strobe), .statusQ(statusQ)
  );

  assign irqOut = globalIrqEn & (|statusQ);

  // with the gate open, the interrupt holds until every bit is cleared
  p_irq_hold_r8: assert property (@(posedge clk) disable iff (rst)
    (irqOut && globalIrqEn && (strobe.clrMask == '0)) |=> (irqOut || !globalIrqEn));
endmodule

// File: tb/tb_edge_irq_top.sv
module tb_edge_irq_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [31:0] lineIn = '0;
  logic [3:0]  busAddr = '0;
  logic        busWrEn = 1'b0;
  logic [7:0]  busWrData = '0;
  logic [7:0]  busRdData;
  logic        globalIrqEn = 1'b0;
  logic        irqOut;

  int nChecks = 0;
  int nFails  = 0;
  bit done = 1'b0;

  // bench model state, stepped once per rising edge
  logic [31:0] mSync1, mSync2, mHist, mStat;
  logic [7:0]  mEn;

  always #4 clk = ~clk;  // 125 MHz

  edge_irq_top dut (.*);

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] modelRead(input logic [3:0] a);
    if (a >= 4'h8 && a <= 4'hB) return mStat[(a-8)*8 +: 8];
    if (a == 4'hE) return mEn;
    return 8'h00;
  endfunction

  function automatic logic [31:0] modelHit();
    logic [31:0] h = '0;
    for (int n = 0; n < 32; n++) begin
      if (mSync2[n] && !mHist[n] && mEn[n/8])     h[n] = 1'b1;
      if (!mSync2[n] && mHist[n] && mEn[4 + n/8]) h[n] = 1'b1;
    end
    return h;
  endfunction

  task automatic modelStep();
    logic [31:0] clr = '0;
    logic [31:0] hit = modelHit();
    if (rst) begin
      mSync1 = '0; mSync2 = '0; mHist = '0; mStat = '0; mEn = '0;
    end else begin
      if (busWrEn && busAddr >= 4'h8 && busAddr <= 4'hB) clr[(busAddr-8)*8 +: 8] = busWrData;
      mStat = (mStat & ~clr) | hit;
      if (busWrEn && busAddr == 4'hE) mEn = busWrData;
      mHist = mSync2; mSync2 = mSync1; mSync1 = lineIn;
    end
  endtask

  // one clock; bus inputs driven 1 ns after the edge
  task automatic cycle(input logic we, input logic [3:0] a, input logic [7:0] d);
    busWrEn = we; busAddr = a; busWrData = d;
    @(posedge clk);
    modelStep();
    #1;
    busWrEn = 1'b0;
  endtask

  task automatic readCheck(input string tag, input logic [3:0] a);
    busAddr = a;
    #1;
    check(tag, {24'h0, busRdData}, {24'h0, modelRead(a)});
  endtask

  task automatic irqCheck(input string tag);
    #1;
    check(tag, {31'h0, irqOut}, {31'h0, globalIrqEn & (|mStat)});
  endtask

  initial begin
    #200000;
    if (!done) begin
      nFails++; nChecks++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("  == %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_0C05));
    // R1: reset
    rst = 1'b1;
    lineIn = 32'hFFFF_0000;
    for (int i = 0; i < 3; i++) cycle(1'b0, 4'h0, 8'h00);
    for (int a = 0; a < 16; a++) begin
      busAddr = 4'(a); #1;
      check("R1 reset read", {24'h0, busRdData}, 32'h0);
    end
    check("R1 reset irq", {31'h0, irqOut}, 32'h0);
    lineIn = '0;
    rst = 1'b0;
    for (int i = 0; i < 4; i++) cycle(1'b0, 4'h0, 8'h00);

    // R2: enable byte round trip
    cycle(1'b1, 4'hE, 8'hA5);
    busAddr = 4'hE; #1;
    check("R2 enable readback", {24'h0, busRdData}, 32'hA5);
    for (int i = 0; i < 4; i++) cycle(1'b0, 4'h0, 8'h00);
    cycle(1'b1, 4'hE, 8'h01);
    cycle(1'b1, 4'h8, 8'hFF); cycle(1'b1, 4'h9, 8'hFF);
    cycle(1'b1, 4'hA, 8'hFF); cycle(1'b1, 4'hB, 8'hFF);

    // R10: latency of exactly three edges
    lineIn[0] = 1'b1;
    cycle(1'b0, 4'h0, 8'h00); busAddr = 4'h8; #1;
    check("R10 edge1 not yet", {24'h0, busRdData}, 32'h0);
    cycle(1'b0, 4'h0, 8'h00); busAddr = 4'h8; #1;
    check("R10 edge2 not yet", {24'h0, busRdData}, 32'h0);
    cycle(1'b0, 4'h0, 8'h00); busAddr = 4'h8; #1;
    check("R10 edge3 set", {24'h0, busRdData}, 32'h1);

    // R7: event and clear of the same bit in one cycle
    lineIn[1] = 1'b1;
    cycle(1'b0, 4'h0, 8'h00);
    cycle(1'b0, 4'h0, 8'h00);
    cycle(1'b1, 4'h8, 8'h03);
    busAddr = 4'h8; #1;
    check("R7 event beats clear", {24'h0, busRdData}, 32'h02);

    // R3: rising on every group, including TTL lines at 0xB
    cycle(1'b1, 4'hE, 8'h0F);
    lineIn = 32'h81_42_24_18 | lineIn;
    for (int i = 0; i < 4; i++) cycle(1'b0, 4'h0, 8'h00);
    busAddr = 4'hB; #1;
    check("R3 ttl group rise", {24'h0, busRdData}, 32'h81);
    for (int a = 8; a < 12; a++) readCheck("R3 rise status", 4'(a));

    // R4: falling only
    for (int a = 8; a < 12; a++) cycle(1'b1, 4'(a), 8'hFF);
    cycle(1'b1, 4'hE, 8'hF0);
    lineIn = 32'h0000_00FF;
    for (int i = 0; i < 4; i++) cycle(1'b0, 4'h0, 8'h00);
    for (int a = 8; a < 12; a++) readCheck("R4 fall status", 4'(a));
    busAddr = 4'hB; #1;
    check("R4 ttl group fall", {24'h0, busRdData}, 32'h81);

    // R5: group0 both directions, group2 none
    for (int a = 8; a < 12; a++) cycle(1'b1, 4'(a), 8'hFF);
    cycle(1'b1, 4'hE, 8'h11);
    lineIn = 32'h00FF_0F00;
    for (int i = 0; i < 4; i++) cycle(1'b0, 4'h0, 8'h00);
    busAddr = 4'h8; #1;
    check("R5 both edges group0", {24'h0, busRdData}, 32'hFF);
    busAddr = 4'hA; #1;
    check("R5 disabled group2", {24'h0, busRdData}, 32'h00);

    // R6: partial clear
    cycle(1'b1, 4'h8, 8'h0F);
    busAddr = 4'h8; #1;
    check("R6 partial clear", {24'h0, busRdData}, 32'hF0);

    // R8: gate and hold
    globalIrqEn = 1'b0; #1;
    check("R8 gated off", {31'h0, irqOut}, 32'h0);
    globalIrqEn = 1'b1;
    cycle(1'b0, 4'h0, 8'h00); irqCheck("R8 gate on");
    cycle(1'b1, 4'h8, 8'h30); irqCheck("R8 still pending");
    check("R8 still pending literal", {31'h0, irqOut}, 32'h1);
    cycle(1'b1, 4'h8, 8'hC0); irqCheck("R8 all cleared");

    // R9: unmapped reads and writes
    cycle(1'b1, 4'hE, 8'h3C);
    lineIn = 32'h0000_0100;
    for (int i = 0; i < 4; i++) cycle(1'b0, 4'h0, 8'h00);
    cycle(1'b1, 4'h3, 8'hFF); cycle(1'b1, 4'hF, 8'hFF); cycle(1'b1, 4'hC, 8'hFF);
    for (int a = 0; a < 16; a++) readCheck("R9 map after stray writes", 4'(a));
    busAddr = 4'hE; #1;
    check("R9 enable untouched", {24'h0, busRdData}, 32'h3C);

    // random mix: toggles, clears, enable changes, gate
    for (int i = 0; i < 600; i++) begin
      logic [3:0] a;
      logic we;
      if ($urandom % 3 == 0) lineIn = lineIn ^ (32'(1) << ($urandom % 32));
      if ($urandom % 9 == 0) lineIn = $urandom;
      if ($urandom % 17 == 0) globalIrqEn = ~globalIrqEn;
      we = ($urandom % 4 == 0);
      a  = ($urandom % 2 == 0) ? 4'(8 + $urandom % 4) : 4'($urandom);
      cycle(we, a, 8'($urandom));
      readCheck("R3 R4 R6 R7 random status", 4'(8 + $urandom % 4));
      readCheck("R2 R9 random map", 4'($urandom));
      irqCheck("R8 random irq");
    end

    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end
endmodule